// File: doc/BRIEF.md
# Dual-Channel Chopping Current Controller

This block regulates winding current in two unipolar stepper channels by fixed-frequency chopping. One shared timebase counts `PERIOD_CYC` system clocks per tick, which is half a chopping period. Successive ticks go to the channels in turn, so each channel gets a set pulse once per chopping period and the two channels are half a period apart. Their current peaks therefore never fall on the same clock.

On its own set pulse, a channel turns its high-side switch on. It also takes a new 2-bit current level as its reference code and starts a blanking count of `LOCKOUT_CYC` clocks. An external sense path compares the winding current with that reference. The result comes back as one comparator bit per channel and passes through a two-flop synchronizer. Once blanking is over, a high synchronized comparator turns the high-side switch off until that channel's next set pulse. While the high-side switch is off, both low-side switches of the channel are on so the winding current can recirculate.

The host sets the chopping period and the blanking length at build time in clock cycles. With the default values and a 100 MHz clock, chopping runs at 20 kHz with a 1.4 us blanking window. Chopping up to 40 kHz is reached by making `PERIOD_CYC` smaller.

Top module: `dual_chop_ctrl`

## Requirements
- R1: Set pulses come once every `PERIOD_CYC` clocks and go to the channels in turn. Channel 0 gets the first one, at the rising edge that ends the `PERIOD_CYC`-th cycle after reset release. Each channel therefore turns on once every 2*`PERIOD_CYC` clocks when its current trips every period.
- R2: The two channels are `PERIOD_CYC` clocks apart, and no two high-side enables turn on at the same edge.
- R3: At the edge that takes its set pulse, a channel drives its high-side enable `hs_en_o[c]` high, whatever the comparator shows.
- R4: After blanking, a comparator high on `comp_i[c]` at rising edge k turns `hs_en_o[c]` low at edge k+2 (two synchronizer flops).
- R5: For the `LOCKOUT_CYC` edges that follow a set edge, the comparator has no effect: `hs_en_o[c]` stays high.
- R6: Low-side enables `ls_en_o[2c+1:2c]` are 2'b11 exactly when `hs_en_o[c]` is low and 2'b00 when it is high, from the first edge after reset release. High-side and low-side switches of a channel are never on together.
- R7: `ref_o[2c+1:2c]` takes `lvl_i[2c+1:2c]` only at the channel's set edge (code 0..3 selects 1/4, 2/4, 3/4, 4/4 of full scale). A level change between set edges does not reach `ref_o`.
- R8: While `rst_ni` is low, all enables and reference codes are 0. After release the timebase starts again from channel 0.
- R9: After a trip, `hs_en_o[c]` stays low until the channel's next set pulse, even if the comparator drops again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset, asynchronous assert |
| lvl_i | input | NCH*2 | Requested current level per channel, 2 bits each |
| comp_i | input | NCH | Current comparator per channel, high = current above reference |
| hs_en_o | output | NCH | High-side switch enable per channel |
| ls_en_o | output | NCH*2 | Low-side recirculation enables, 2 per channel |
| ref_o | output | NCH*2 | Reference code per channel, as taken at the last set edge |

## Verification
A comparator held low shows that set pulses alone turn the switches on and keep them on across periods. A comparator held high shows the pure blanking width and the exact half-period offset between channels. A pseudo-random comparator stream separates trips that land inside blanking (ignored) from trips that land after it, and shows that a comparator which drops again does not turn the switch back on. Level changes between set edges and a reset in mid-run show when the reference code updates and that the timebase restarts on channel 0.

// File: rtl/chop_pkg.sv
package chop_pkg;
  // width of the per-channel current level code
  localparam int unsigned LVL_W = 2;
  // low-side recirculation switches per unipolar channel
  localparam int unsigned NLS   = 2;

  typedef logic [LVL_W-1:0] lvl_t;

  typedef struct packed {
    logic           hs;
    logic [NLS-1:0] ls;
    lvl_t           lvl;
  } chan_out_t;
endpackage

// File: rtl/chop_sync2.sv
module chop_sync2 #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/chop_timebase.sv
module chop_timebase #(
  parameter int unsigned NCH        = 2,
  parameter int unsigned PERIOD_CYC = 2500
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  output logic [NCH-1:0] sync_o
);
  localparam int unsigned CNT_W = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
  localparam int unsigned PH_W  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PERIOD_CYC - 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(NCH - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic             tick;

  always_comb begin
    tick  = (cnt_q == CNT_LAST);
    cnt_d = tick ? '0 : cnt_q + CNT_W'(1);
    ph_d  = ph_q;
    if (tick) ph_d = (ph_q == PH_LAST) ? '0 : ph_q + PH_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_sync
    assign sync_o[c] = tick && (ph_q == PH_W'(c));
  end
endmodule

// File: rtl/chop_channel.sv
module chop_channel
  import chop_pkg::*;
#(
  parameter int unsigned LOCKOUT_CYC = 140
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sync_i,
  input  logic      trip_i,
  input  lvl_t      lvl_i,
  output chan_out_t out_o
);
  localparam int unsigned LK_W = $clog2(LOCKOUT_CYC + 1);
  localparam logic [LK_W-1:0] LK_LOAD = LK_W'(LOCKOUT_CYC);

  logic            hs_q, hs_d;
  logic [NLS-1:0]  ls_q, ls_d;
  lvl_t            ref_q, ref_d;
  logic [LK_W-1:0] lock_q, lock_d;
  logic            blank;

  always_comb begin
    blank  = (lock_q != '0);
    hs_d   = hs_q;
    lock_d = lock_q;
    ref_d  = ref_q;
    if (sync_i) begin
      hs_d   = 1'b1;
      lock_d = LK_LOAD;
      ref_d  = lvl_i;
    end else if (blank) begin
      lock_d = lock_q - LK_W'(1);
    end else if (trip_i) begin
      hs_d   = 1'b0;
    end
    ls_d = {NLS{~hs_d}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q   <= 1'b0;
      ls_q   <= '0;
      ref_q  <= '0;
      lock_q <= '0;
    end else begin
      hs_q   <= hs_d;
      ls_q   <= ls_d;
      ref_q  <= ref_d;
      lock_q <= lock_d;
    end
  end

  assign out_o.hs  = hs_q;
  assign out_o.ls  = ls_q;
  assign out_o.lvl = ref_q;
endmodule

// File: rtl/dual_chop_ctrl.sv
module dual_chop_ctrl
  import chop_pkg::*;
#(
  parameter int unsigned NCH         = 2,
  parameter int unsigned PERIOD_CYC  = 2500,
  parameter int unsigned LOCKOUT_CYC = 140
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NCH*LVL_W-1:0] lvl_i,
  input  logic [NCH-1:0]       comp_i,
  output logic [NCH-1:0]       hs_en_o,
  output logic [NCH*NLS-1:0]   ls_en_o,
  output logic [NCH*LVL_W-1:0] ref_o
);
  if (LOCKOUT_CYC < 1 || 2 * LOCKOUT_CYC >= PERIOD_CYC) begin : g_bad_lockout
    $error("blanking must be at least one cycle and shorter than half a tick");
  end

  logic [NCH-1:0] sync_w;
  logic [NCH-1:0] trip_w;

  chop_timebase #(
    .NCH        (NCH),
    .PERIOD_CYC (PERIOD_CYC)
  ) u_tb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_o (sync_w)
  );

  chop_sync2 #(
    .W (NCH)
  ) u_csync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (comp_i),
    .q_o    (trip_w)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    chan_out_t ch_out;

    chop_channel #(
      .LOCKOUT_CYC (LOCKOUT_CYC)
    ) u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sync_i (sync_w[c]),
      .trip_i (trip_w[c]),
      .lvl_i  (lvl_i[c*LVL_W +: LVL_W]),
      .out_o  (ch_out)
    );

    assign hs_en_o[c]               = ch_out.hs;
    assign ls_en_o[c*NLS +: NLS]    = ch_out.ls;
    assign ref_o[c*LVL_W +: LVL_W]  = ch_out.lvl;
  end
endmodule

// File: rtl/chop_ctrl_chk.sv
module chop_ctrl_chk #(
  parameter int unsigned NCH   = 2,
  parameter int unsigned LVL_W = 2,
  parameter int unsigned NLS   = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NCH-1:0]       sync_v,
  input logic [NCH-1:0]       trip_v,
  input logic [NCH-1:0]       hs,
  input logic [NCH*NLS-1:0]   ls,
  input logic [NCH*LVL_W-1:0] refc
);
  // R2
  sync_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sync_v));

  // R2
  rise_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hs & ~$past(hs)));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R3
    sync_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_v[c] |=> hs[c]);

    // R5
    lockout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs[c]) |=> hs[c]);

    // R4
    trip_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hs[c]) |-> ($past(trip_v[c]) && !$past(sync_v[c])));

    // R9
    stay_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hs[c] && !sync_v[c]) |=> !hs[c]);

    // R6
    ls_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hs[c] |-> (ls[c*NLS +: NLS] == '0));

    // R7
    ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(refc[c*LVL_W +: LVL_W]) |-> $past(sync_v[c]));
  end
endmodule

bind dual_chop_ctrl chop_ctrl_chk #(
  .NCH   (NCH),
  .LVL_W (chop_pkg::LVL_W),
  .NLS   (chop_pkg::NLS)
) u_chk (
  .clk    (clk_i),
  .rst_n  (rst_ni),
  .sync_v (sync_w),
  .trip_v (trip_w),
  .hs     (hs_en_o),
  .ls     (ls_en_o),
  .refc   (ref_o)
);

// File: tb/test_dual_chop_ctrl.sv
`timescale 1ns/1ps
module test_dual_chop_ctrl;
  localparam int P = 40;
  localparam int L = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] lvl = 4'h0;
  logic [1:0] comp = 2'b00;
  logic [1:0] hs;
  logic [3:0] ls;
  logic [3:0] refc;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_chop_ctrl #(
    .NCH (2), .PERIOD_CYC (P), .LOCKOUT_CYC (L)
  ) i_dual_chop_ctrl (
    .clk_i (clk), .rst_ni (rst_n), .lvl_i (lvl), .comp_i (comp),
    .hs_en_o (hs), .ls_en_o (ls), .ref_o (refc)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, updated on each rising edge
  int m_cnt, m_ph;
  int m_hs[2], m_lock[2], m_ls[2], m_ref[2], m_c1[2], m_c2[2];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_ph = 0;
      for (int c = 0; c < 2; c++) begin
        m_hs[c] = 0; m_lock[c] = 0; m_ls[c] = 0; m_ref[c] = 0; m_c1[c] = 0; m_c2[c] = 0;
      end
    end else begin
      bit tick;
      tick = (m_cnt == P - 1);
      for (int c = 0; c < 2; c++) begin
        if (tick && m_ph == c) begin
          m_hs[c] = 1; m_lock[c] = L; m_ref[c] = (lvl >> (2 * c)) & 3;
        end else if (m_lock[c] > 0) begin
          m_lock[c] = m_lock[c] - 1;
        end else if (m_c2[c] != 0) begin
          m_hs[c] = 0;
        end
        m_ls[c] = m_hs[c] ? 0 : 3;
        m_c2[c] = m_c1[c];
        m_c1[c] = comp[c];
      end
      m_cnt = tick ? 0 : m_cnt + 1;
      if (tick) m_ph = 1 - m_ph;
    end
  end

  // per-cycle compare and rise spacing, sampled at the falling edge
  bit steady = 1'b0;
  int cyc = 0;
  int last_rise[2];
  logic [1:0] hs_prev = 2'b00;

  always @(negedge clk) begin
    cyc++;
    for (int c = 0; c < 2; c++) begin
      string tg;
      tg = !rst_n ? "R8" : "R3/R4/R5/R9";
      chk(hs[c] == m_hs[c][0], tg, hs[c], m_hs[c]);
      chk(int'(ls[2*c +: 2]) == m_ls[c], !rst_n ? "R8" : "R6", ls[2*c +: 2], m_ls[c]);
      chk(int'(refc[2*c +: 2]) == m_ref[c], !rst_n ? "R8" : "R7", refc[2*c +: 2], m_ref[c]);
      if (steady && hs[c] && !hs_prev[c]) begin
        if (last_rise[c] >= 0)     chk(cyc - last_rise[c] == 2 * P, "R1", cyc - last_rise[c], 2 * P);
        if (last_rise[1-c] >= 0)   chk(cyc - last_rise[1-c] == P, "R2", cyc - last_rise[1-c], P);
        last_rise[c] = cyc;
      end
    end
    hs_prev = hs;
  end

  int seed = 32'h1d2c3b4a;

  task automatic run(input int n, input bit rnd);
    repeat (n) begin
      @(negedge clk);
      if (rnd) begin
        seed = seed * 1103515245 + 12345;
        comp = seed[17:16];
      end
    end
  endtask

  initial begin
    last_rise[0] = -1; last_rise[1] = -1;
    repeat (3) @(negedge clk);
    // R8: everything low in reset
    chk(hs == 2'b00 && ls == 4'h0 && refc == 4'h0, "R8", {hs, ls, refc}, 0);
    @(negedge clk); #1 rst_n = 1'b1;
    lvl = 4'b10_01;
    // R3: comparator low, switches come on and stay on
    run(3 * P, 1'b0);
    chk(hs == 2'b11, "R3", hs, 3);
    // R1/R2/R5: comparator always high
    comp = 2'b11;
    steady = 1'b1;
    run(8 * P, 1'b0);
    steady = 1'b0;
    chk(last_rise[0] >= 0 && last_rise[1] >= 0, "R1", last_rise[0], 0);
    // R4/R5/R9: pseudo-random comparator
    run(10 * P, 1'b1);
    // R7: level changes between set pulses
    lvl = 4'b00_11;
    run(P / 2, 1'b1);
    lvl = 4'b11_10;
    run(3 * P, 1'b1);
    // R8: reset in mid-run, timebase restarts on channel 0
    @(negedge clk); #1 rst_n = 1'b0;
    run(3, 1'b1);
    chk(hs == 2'b00 && refc == 4'h0, "R8", {hs, refc}, 0);
    @(negedge clk); #1 rst_n = 1'b1;
    comp = 2'b00;
    run(P, 1'b0);
    chk(hs == 2'b01, "R8", hs, 1);
    run(4 * P, 1'b1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule